// File: doc/BRIEF.md
# Variable-Frequency Tick Generator

This block is a numerically controlled oscillator that runs on the reference clock. A 16-bit phase accumulator advances by a step taken from a 16-bit control word on every enabled clock. The accumulator's top bit is the square-wave output. A one-clock tick marks each rising edge of that output, and a downstream constant-frequency pulse-width stage uses the tick as its time base.

The step comes from the control word. Words below 2^15 are used as they are. Words of 2^15 and above are replaced by their 16-bit two's complement, so 0xFF00 runs at the same rate as 0x0100. The output rate is the step divided by 2^16, times the reference clock. A power-of-two word gives an even square wave. A zero word, a low enable or a reset holds the output low and produces no ticks.

Top module: `nco_cword_gen`

## Requirements
- R1: An asserted active-low reset clears the accumulator at once, so that `sq_out` and `tick` are both 0 until the first enabled clock after release.
- R2: For a control word below 0x8000, the step equals the word, the accumulator adds the step on each enabled rising clock edge modulo 2^16, and `sq_out` is accumulator bit 15.
- R3: For a control word of 0x8000 or above, the step is 2^16 minus the word. For example, 0xFF00 steps by 0x0100 and 0x8000 steps by 0x8000.
- R4: While `en` is low, the accumulator is zero after the next clock edge, `sq_out` is 0 and `tick` stays 0.
- R5: A control word of 0 with `en` high keeps `sq_out` at 0 and never raises `tick`.
- R6: `tick` is high for exactly one clock, in the same cycle that `sq_out` goes from 0 to 1. It is never high in two consecutive cycles.
- R7: A power-of-two control word gives a 50% duty square wave. With word 0x0400, `sq_out` is high for 512 of 1024 clocks.
- R8: The tick rate is step/2^16 of the clock. Starting from a cleared accumulator, word 0x0100 gives exactly 4 ticks in 1024 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the accumulator |
| cword | input | 16 | Frequency control word |
| sq_out | output | 1 | Variable-frequency square wave (accumulator MSB) |
| tick | output | 1 | One-clock pulse on each rising edge of `sq_out` |

## Verification
A wrong accumulator value shows up at `sq_out` only when it changes bit 15. With a small step, the error can therefore stay hidden for up to 2^15/step clocks. For this reason, the bench compares every cycle over runs longer than one output period. A wrong step decode for upper-half words appears as a shifted tick count within a few hundred clocks. A tick register that is out of step with the MSB fails the first rising edge after enable.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int NCO_W = 16;
  typedef logic [NCO_W-1:0] word_t;

  // Effective phase increment: upper-half words are folded by negation.
  function automatic word_t eff_step(input word_t cw);
    word_t s;
    if (cw[NCO_W-1])
      s = word_t'(~cw + word_t'(1));
    else
      s = cw;
    return s;
  endfunction

  // Next phase value, wrapping modulo 2^NCO_W.
  function automatic word_t phase_next(input word_t acc, input word_t step);
    return word_t'(acc + step);
  endfunction
endpackage

// File: rtl/nco_step_decode.sv
module nco_step_decode
  import nco_pkg::*;
(
  input  word_t cword,
  output word_t step
);
  assign step = eff_step(cword);

  // R3: a folded step never exceeds half the phase circle
  always_comb begin
    a_r3_step_bound: assert (step <= word_t'(1 << (NCO_W-1)));
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  word_t step,
  output word_t acc,
  output logic  msb_rise
);
  word_t nxt;

  always_comb begin
    nxt      = phase_next(acc, step);
    msb_rise = en & ~acc[NCO_W-1] & nxt[NCO_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc <= '0;
    else if (!en)
      acc <= '0;
    else
      acc <= nxt;
  end

  // R4: disable clears the phase on the following edge
  a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc == '0));

  // R5: a zero step leaves the phase untouched
  a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step == '0) |=> $stable(acc));
endmodule

// File: rtl/nco_rise_tick.sv
module nco_rise_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_in,
  output logic tick
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tick <= 1'b0;
    else
      tick <= rise_in;
  end
endmodule

// File: rtl/nco_cword_gen.sv
module nco_cword_gen
  import nco_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NCO_W-1:0]     cword,
  output logic                 sq_out,
  output logic                 tick
);
  word_t step;
  word_t acc;
  logic  msb_rise;

  nco_step_decode u_dec (
    .cword (cword),
    .step  (step)
  );

  nco_phase_acc u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .step     (step),
    .acc      (acc),
    .msb_rise (msb_rise)
  );

  nco_rise_tick u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_in (msb_rise),
    .tick    (tick)
  );

  assign sq_out = acc[NCO_W-1];

  // R6: a tick coincides with a 0-to-1 step of the square wave
  a_r6_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (sq_out && !$past(sq_out)));

  // R6: a tick lasts a single clock
  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: tb/test_nco_cword_gen.sv
`timescale 1ns/1ps
module test_nco_cword_gen;
  typedef struct {
    logic  sq;
    logic  tk;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] cword = '0;
  logic        sq_out, tick;

  exp_t q[$];
  int   tests = 0, fails = 0;
  int   tick_cnt = 0, hi_cnt = 0;
  int   m_acc = 0;

  always #5 clk = ~clk;

  nco_cword_gen i_nco_cword_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .cword(cword),
    .sq_out(sq_out), .tick(tick)
  );

  // Driver: set inputs at the falling edge and push the expected result
  task automatic drive(input logic r, input logic e, input int cw, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t it;
      int   w, old_msb;
      @(negedge clk);
      rst_n = r; en = e; cword = cw[15:0];
      w = (cw >= 32768) ? 65536 - cw : cw;
      old_msb = m_acc / 32768;
      if (!r || !e) m_acc = 0;
      else m_acc = (m_acc + w) % 65536;
      it.sq  = logic'(m_acc / 32768);
      it.tk  = logic'(r && e && old_msb == 0 && (m_acc / 32768) == 1);
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_count(input string tag, input int got, input int exp_v);
    tests++;
    if (got != exp_v) begin
      fails++;
      $display("FAIL %s count actual=%0d expected=%0d", tag, got, exp_v);
    end
  endtask

  // Monitor: sample after the active edge and compare
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        tests++;
        tick_cnt += int'(tick);
        hi_cnt   += int'(sq_out);
        if (sq_out !== it.sq || tick !== it.tk) begin
          fails++;
          $display("FAIL %s sq/tick actual=%b/%b expected=%b/%b", it.tag, sq_out, tick, it.sq, it.tk);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    drive(1'b0, 1'b1, 16'h1234, 3, "R1");            // reset state
    drive(1'b1, 1'b1, 16'h1234, 300, "R2");          // plain word, R6 ticks
    drive(1'b1, 1'b1, 16'h7FFF, 20, "R2");           // top of lower half
    drive(1'b0, 1'b1, 16'h7FFF, 2, "R1");            // mid-run reset
    drive(1'b1, 1'b1, 16'h8000, 10, "R3");           // folds to 0x8000
    drive(1'b1, 1'b1, 16'hC001, 200, "R3");          // folds to 0x3FFF
    drive(1'b1, 1'b0, 16'hC001, 5, "R4");            // disable clears
    drive(1'b1, 1'b1, 16'h0000, 50, "R5");           // zero word idles
    drive(1'b1, 1'b1, 16'h2000, 40, "R6");           // tick pulses
    drive(1'b1, 1'b0, 16'h0000, 2, "R4");
    drain(); tick_cnt = 0; hi_cnt = 0;
    drive(1'b1, 1'b1, 16'h0400, 1024, "R7");
    drain(); check_count("R7", hi_cnt, 512);
    drive(1'b1, 1'b0, 16'h0000, 2, "R4");
    drain(); tick_cnt = 0;
    drive(1'b1, 1'b1, 16'h0100, 1024, "R8");
    drain(); check_count("R8", tick_cnt, 4);
    drive(1'b1, 1'b0, 16'h0000, 2, "R4");
    drain(); tick_cnt = 0;
    drive(1'b1, 1'b1, 16'hFF00, 1024, "R3");
    drain(); check_count("R3", tick_cnt, 4);
    drain(); tick_cnt = 0;
    drive(1'b1, 1'b1, 16'h0000, 100, "R5");
    drain(); check_count("R5", tick_cnt, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule